// File: doc/BRIEF.md
# Serial Multichannel ADC Command and Readout Interface

This block is the digital side of a multichannel serial analog-to-digital converter. A host talks to it over a four-wire SPI link: an active-low chip select, a serial clock idling low, a command input and a data output whose driver is released whenever chip select is high. Each frame carries a 16-bit command word, MSB first. The top nibble selects the action: start a conversion on one of nine inputs, write or read the configuration register, or read the oldest entry of a small result queue. While the command arrives, the block shifts out the word chosen by the previous frame.

Conversions are timed by the system clock. A conversion begins at the sixteenth falling serial-clock edge and lasts a fixed, parameterised number of system clocks. At the end, the block captures the code from a parallel port that stands in for the converter core. A single open-drain-style status pin reports progress. In end-of-conversion style it stays low for the whole conversion. In interrupt style it drops when a result is ready and is released by the next chip-select fall. A new chip-select fall during a conversion abandons that conversion.

The serial inputs are asynchronous to the system clock. They are resynchronised inside the block, so the serial clock must run well below the system clock (at least eight system clocks per half period).

Top module: `serial_adc_if`

## Requirements
- R1: After reset, `sdo_oe` is 0, `eoc_n` is 1, `conv_active` is 0, the configuration register is 0 (end-of-conversion style) and the result register and queue are empty or zero.
- R2: `sdo_oe` is 1 while `cs_n` is low and 0 while it is high, with a lag of a few system clocks. `sdo` is 0 whenever `sdo_oe` is 0.
- R3: Output words go MSB first. Bit 15 is on `sdo` before the first rising `sclk` edge, and each rising edge advances to the next bit. A 12-bit result is sent left-justified as {code, 4'b0000}.
- R4: Command nibbles 0x0 to 0x8 start a conversion of that channel at the 16th falling `sclk` edge. `conv_active` is 1 and `conv_chan` shows the channel for CONV_CYCLES system clocks. At the end, `adc_code` is captured, and the next frame returns it.
- R5: Nibble 0xA copies command bits [11:0] into the configuration register. Nibble 0x9 makes the next frame return {4'h0, config}. Neither starts a conversion.
- R6: With config bit 1 at 0 (end-of-conversion style), `eoc_n` is low from the 16th falling edge of a converting frame until that conversion ends, and high otherwise.
- R7: With config bit 1 at 1 (interrupt style), `eoc_n` goes low when a conversion ends and returns high at the next `cs_n` fall. It stays high during a conversion.
- R8: A `cs_n` fall while `conv_active` is 1 abandons the conversion. `conv_active` drops, `eoc_n` is high, and neither the result register nor the queue changes.
- R9: Nibble 0xE makes the next frame pop and return the oldest queued result (left-justified), or 0x0000 if the queue is empty. It also starts a conversion on the channel most recently selected by 0x0 to 0x8 (0 after reset).
- R10: Every completed conversion is pushed into a FIFO_DEPTH-entry queue. A result that arrives while the queue is full is dropped from the queue, but it still updates the result register.
- R11: Nibbles 0xB, 0xC, 0xD and 0xF start no conversion and leave the configuration unchanged. The next frame returns the latest result.
- R12: A frame with fewer than 16 rising `sclk` edges has no effect beyond its readout. Edges after the 16th are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host, idles low |
| sdi | input | 1 | Command bits from host, sampled on rising `sclk` |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable of the `sdo` driver (0 = high impedance) |
| eoc_n | output | 1 | Conversion status / interrupt pin, active low |
| conv_active | output | 1 | A conversion is running in the converter core |
| conv_chan | output | 4 | Channel of the running conversion |
| adc_code | input | RES_W | Code from the converter core, captured when a conversion ends |

## Verification
The hardest situation to bring about is a chip-select fall that lands while a conversion is still running. It must leave no trace in the result register or the queue, and the very next readout must still show the older value. The stimulus gets there by following some converting frames with a short gap instead of the full conversion time, both in directed order and at random. A full queue is also hard to reach: it takes several back-to-back completed conversions with no queue read between them, followed by more reads than entries.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  localparam int FRAME_W = 16;
  localparam int CMD_W   = 4;

  localparam logic [CMD_W-1:0] CMD_LAST_CHAN = 4'h8;
  localparam logic [CMD_W-1:0] CMD_CFG_READ  = 4'h9;
  localparam logic [CMD_W-1:0] CMD_CFG_WRITE = 4'hA;
  localparam logic [CMD_W-1:0] CMD_Q_READ    = 4'hE;

  typedef enum logic [1:0] {
    SEL_RESULT = 2'd0,
    SEL_CONFIG = 2'd1,
    SEL_QUEUE  = 2'd2
  } out_sel_e;
endpackage

// File: rtl/spi_slave_fe.sv
module spi_slave_fe #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               cs_fall,
  output logic               cs_active,
  output logic               frame_done,
  output logic [FRAME_W-1:0] rx_word,
  output logic               sdo_bit
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [2:0] cs_q, sk_q;
  logic [1:0] sd_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME_W-1:0] rx_sh, tx_sh;
  logic done_seen;
  logic sck_rise, sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 3'b111;
      sk_q <= 3'b000;
      sd_q <= 2'b00;
    end else begin
      cs_q <= {cs_q[1:0], cs_n};
      sk_q <= {sk_q[1:0], sclk};
      sd_q <= {sd_q[0], sdi};
    end
  end

  assign cs_active = ~cs_q[1];
  assign cs_fall   = cs_q[2] & ~cs_q[1];
  assign sck_rise  = ~sk_q[2] & sk_q[1];
  assign sck_fall  = sk_q[2] & ~sk_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      done_seen <= 1'b0;
    end else if (cs_fall) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= tx_word;
      done_seen <= 1'b0;
    end else if (cs_active) begin
      if (sck_rise && bit_cnt < FULL) begin
        rx_sh   <= {rx_sh[FRAME_W-2:0], sd_q[1]};
        tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (frame_done) done_seen <= 1'b1;
    end
  end

  assign frame_done = cs_active & sck_fall & (bit_cnt == FULL) & ~done_seen;
  assign rx_word    = rx_sh;
  assign sdo_bit    = tx_sh[FRAME_W-1];

  // R12
  bit_cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);

  // R12
  one_done_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int CONV_CYCLES = 350,
  parameter int CH_W        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic [CH_W-1:0] chan_in,
  output logic            busy,
  output logic [CH_W-1:0] chan,
  output logic            done
);
  localparam int TW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [TW-1:0] LOAD = TW'(CONV_CYCLES - 1);

  logic [TW-1:0] timer;

  assign done = busy & (timer == '0) & ~abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      timer <= '0;
      chan  <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      timer <= LOAD;
      chan  <= chan_in;
    end else if (busy && (abort || done)) begin
      busy <= 1'b0;
    end else if (busy) begin
      timer <= timer - 1'b1;
    end
  end

  // R8
  abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort && !start) |=> !busy);

  // R4
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R4
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> $stable(chan));
endmodule

// File: rtl/result_fifo.sv
module result_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CAP);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/serial_adc_if.sv
module serial_adc_if
  import adc_if_pkg::*;
#(
  parameter int CONV_CYCLES = 350,
  parameter int RES_W       = 12,
  parameter int CFG_W       = 12,
  parameter int FIFO_DEPTH  = 4,
  parameter int INT_BIT     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             eoc_n,
  output logic             conv_active,
  output logic [3:0]       conv_chan,
  input  logic [RES_W-1:0] adc_code
);
  localparam int PAD_W = FRAME_W - RES_W;
  localparam int CPAD  = FRAME_W - CFG_W;

  logic cs_fall, cs_active, frame_done, sdo_bit;
  logic [FRAME_W-1:0] rx_word, tx_word;
  logic [CMD_W-1:0] cmd, start_chan, last_chan;
  logic is_chan, conv_start, conv_done, conv_busy;
  logic fifo_pop, fifo_empty, fifo_full;
  logic [RES_W-1:0] fifo_dout, result_q;
  logic [CFG_W-1:0] cfg_q;
  out_sel_e pend_sel;
  logic eoc_q, int_mode;

  spi_slave_fe #(.FRAME_W(FRAME_W)) u_fe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .tx_word(tx_word), .cs_fall(cs_fall), .cs_active(cs_active),
    .frame_done(frame_done), .rx_word(rx_word), .sdo_bit(sdo_bit)
  );

  assign cmd        = rx_word[FRAME_W-1 -: CMD_W];
  assign is_chan    = (cmd <= CMD_LAST_CHAN);
  assign conv_start = frame_done & (is_chan | (cmd == CMD_Q_READ));
  assign start_chan = is_chan ? cmd : last_chan;
  assign int_mode   = cfg_q[INT_BIT];

  conv_seq #(.CONV_CYCLES(CONV_CYCLES), .CH_W(CMD_W)) u_conv (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .abort(cs_fall),
    .chan_in(start_chan), .busy(conv_busy), .chan(conv_chan), .done(conv_done)
  );

  assign fifo_pop = cs_fall & (pend_sel == SEL_QUEUE);

  result_fifo #(.W(RES_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(conv_done), .din(adc_code),
    .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
  );

  always_comb begin
    case (pend_sel)
      SEL_CONFIG: tx_word = {{CPAD{1'b0}}, cfg_q};
      SEL_QUEUE:  tx_word = fifo_empty ? '0 : {fifo_dout, {PAD_W{1'b0}}};
      default:    tx_word = {result_q, {PAD_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      result_q  <= '0;
      last_chan <= '0;
      pend_sel  <= SEL_RESULT;
    end else begin
      if (conv_done) result_q <= adc_code;
      if (cs_fall) begin
        pend_sel <= SEL_RESULT;
      end else if (frame_done) begin
        if (cmd == CMD_CFG_READ)   pend_sel <= SEL_CONFIG;
        else if (cmd == CMD_Q_READ) pend_sel <= SEL_QUEUE;
        if (cmd == CMD_CFG_WRITE)  cfg_q <= rx_word[CFG_W-1:0];
        if (is_chan)               last_chan <= cmd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_q <= 1'b1;
    end else if (int_mode) begin
      if (conv_done)    eoc_q <= 1'b0;
      else if (cs_fall) eoc_q <= 1'b1;
    end else begin
      if (conv_start)                eoc_q <= 1'b0;
      else if (conv_done || cs_fall) eoc_q <= 1'b1;
    end
  end

  assign eoc_n       = eoc_q;
  assign conv_active = conv_busy;
  assign sdo_oe      = cs_active;
  assign sdo         = cs_active & sdo_bit;

  // R6
  eoc_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_mode && conv_busy) |-> !eoc_n);

  // R7
  int_idle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && conv_busy) |-> eoc_n);

  // R7
  int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mode && cs_fall) |=> eoc_n);

  // R8
  abort_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && conv_busy) |=> $stable(result_q));

  // R5
  cfg_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && cmd == CMD_CFG_WRITE) |=> $stable(cfg_q));
endmodule

// File: tb/sim_serial_adc_if.sv
module sim_serial_adc_if;
  localparam int CONV = 350;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, eoc_n, conv_active;
  logic [3:0] conv_chan;
  logic [11:0] adc_code = '0;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [11:0] m_cfg, m_result, m_code;
  logic [11:0] m_fifo [4];
  int m_cnt, m_pend;
  logic [3:0] m_last;
  bit m_busy;

  always #5 clk = ~clk;

  serial_adc_if u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .eoc_n(eoc_n), .conv_active(conv_active),
    .conv_chan(conv_chan), .adc_code(adc_code)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] expect_word();
    logic [15:0] w;
    if (m_pend == 1) w = {4'h0, m_cfg};
    else if (m_pend == 2) begin
      if (m_cnt > 0) begin
        w = {m_fifo[0], 4'h0};
        for (int k = 0; k < 3; k++) m_fifo[k] = m_fifo[k+1];
        m_cnt--;
      end else w = 16'h0000;
    end else w = {m_result, 4'h0};
    return w;
  endfunction

  task automatic frame(input logic [15:0] cmd, input int nclk, input bit long_wait);
    logic [15:0] exp_w, got;
    logic [3:0] c;
    logic [3:0] ch;
    bit conv;
    got = '0;
    m_code = 12'($urandom);
    adc_code = m_code;
    exp_w = expect_word();
    m_pend = 0;
    m_busy = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    check("R2 oe while selected", 32'(sdo_oe), 32'd1);
    check("R8/R7 pin released at select", 32'(eoc_n), 32'd1);
    check("R8 no conversion after select", 32'(conv_active), 32'd0);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? cmd[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 16) got[15-i] = sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    c = cmd[15:12];
    if (nclk >= 16) begin
      check("R3/R5/R9/R11 readout word", 32'(got), 32'(exp_w));
      conv = 0;
      ch = 4'h0;
      if (c <= 4'h8) begin conv = 1; ch = c; m_last = c; end
      else if (c == 4'hE) begin conv = 1; ch = m_last; m_pend = 2; end
      else if (c == 4'h9) m_pend = 1;
      else if (c == 4'hA) m_cfg = cmd[11:0];
      if (conv) begin
        m_busy = 1;
        check("R4 conversion running", 32'(conv_active), 32'd1);
        check("R4 channel shown", 32'(conv_chan), 32'(ch));
        check("R6/R7 pin during conversion", 32'(eoc_n), m_cfg[1] ? 32'd1 : 32'd0);
      end else begin
        check("R5/R11 no conversion", 32'(conv_active), 32'd0);
      end
    end else begin
      check("R12 short frame no conversion", 32'(conv_active), 32'd0);
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 released when deselected", 32'({sdo_oe, sdo}), 32'd0);
    if (long_wait) begin
      repeat (CONV + 20) @(negedge clk);
      if (m_busy) begin
        m_result = m_code;
        if (m_cnt < 4) begin m_fifo[m_cnt] = m_code; m_cnt++; end
        m_busy = 0;
        check("R4 conversion ended", 32'(conv_active), 32'd0);
        check("R6/R7 pin after conversion", 32'(eoc_n), m_cfg[1] ? 32'd0 : 32'd1);
      end
    end else begin
      repeat (30) @(negedge clk);
    end
  endtask

  initial begin
    #2ms;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] pick;
    int n;
    void'($urandom(32'd1234));
    m_cfg = '0; m_result = '0; m_cnt = 0; m_pend = 0; m_last = '0; m_busy = 0;
    for (int k = 0; k < 4; k++) m_fifo[k] = '0;
    repeat (4) @(negedge clk);
    check("R1 oe at reset", 32'(sdo_oe), 32'd0);
    check("R1 pin at reset", 32'(eoc_n), 32'd1);
    check("R1 idle at reset", 32'(conv_active), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    frame(16'h9000, 16, 1);      // R1 config reads zero next
    frame(16'hA000, 16, 1);      // R5 EOC style
    frame(16'h3000, 16, 1);      // R4 channel 3
    frame(16'h9000, 16, 1);      // R3 result back
    frame(16'hB123, 16, 1);      // R11 reserved, returns config
    frame(16'h5000, 16, 0);      // R8 start then abort
    frame(16'h0000, 16, 1);      // R8 old result returned
    frame(16'h7000, 16, 1);      // R10 fill queue
    frame(16'h8000, 16, 1);
    frame(16'h1000, 16, 1);
    frame(16'h2000, 16, 1);      // R10 dropped when full
    for (int k = 0; k < 6; k++) frame(16'hE000, 16, (k != 2)); // R9 drain
    frame(16'h2000, 8, 1);       // R12 short frame
    frame(16'h6000, 20, 1);      // R12 extra clocks ignored
    frame(16'hA002, 16, 1);      // R7 interrupt style
    frame(16'h4000, 16, 1);
    frame(16'h4000, 16, 0);      // R7/R8 abort in interrupt style
    frame(16'hF000, 16, 1);      // R11
    frame(16'h9000, 16, 1);
    frame(16'hA000, 16, 1);

    for (int r = 0; r < 55; r++) begin
      case ($urandom_range(0, 5))
        0, 1: pick = 4'($urandom_range(0, 8));
        2: pick = 4'hE;
        3: pick = 4'h9;
        4: pick = 4'hA;
        default: pick = 4'($urandom_range(11, 15));
      endcase
      n = ($urandom_range(0, 7) == 0) ? int'($urandom_range(4, 19)) : 16;
      frame({pick, 12'($urandom)}, n, ($urandom_range(0, 3) != 0));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule